// File: doc/BRIEF.md
# Serial Gain-Control Word Receiver

This block is the digital front end of a four-channel programmable-gain array. A host sends 8-bit control words one bit at a time on a serial clock and data pair. A separate strobe then commits the word. The strobe is offered as two pins of opposite polarity, and a board may wire either one. Each committed word can rewrite one of four 4-bit gain codes. The block drives those codes, plus a mute flag for each channel, to the analog stages.

Each word carries four fields. The top bit enables the whole word. The next bit is compared with a chip-select strap, which lets two receivers share one serial bus. Two bits pick the channel, and the low four bits are the new gain code. Code zero means the channel is off (muted). All serial pins are asynchronous to the system clock. They are resynchronized, and the block acts only on edges of the resynchronized samples. The system clock must run at least four times faster than the serial clock.

Top module: `gain_word_rx`

## Requirements
- R1: After reset, every gain code reads 0000, every mute flag reads 1, and no update pulse appears.
- R2: Data is sampled on each rising serial-clock edge and shifted in most significant bit first. The committed word is always the last 8 bits received, however many clock pulses came before the strobe.
- R3: A committed word whose bit 7 is 0 changes no gain code and raises no update pulse.
- R4: A word is accepted only when its bit 6 equals the level of the chip-select input.
- R5: Bits 5:4 select the target channel: 00 selects channel 0, 01 selects channel 1, 10 selects channel 2 and 11 selects channel 3. Bits 3:0 become that channel's gain code, found at gain_o[4*ch+3:4*ch].
- R6: Shifting bits in, without a commit, leaves every gain code and mute flag unchanged.
- R7: A commit happens on the falling edge of the active-high strobe or on the rising edge of the active-low strobe. The opposite edges never commit.
- R8: A channel's mute flag is 1 exactly when its gain code is 0000.
- R9: Each accepted word raises upd_o for exactly one system clock cycle. upd_ch_o carries the written channel's index in that same cycle.
- R10: The shift register keeps its contents after a commit, so a later strobe with no new shifting commits the same word again.
- R11: A strobe pin held static at either level never causes a commit, so each strobe pin can be used alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| strb_hi_i | input | 1 | Active-high strobe, commits on its falling edge |
| strb_lo_i | input | 1 | Active-low strobe, commits on its rising edge |
| chip_sel_i | input | 1 | Static device-select strap, compared with bit 6 |
| gain_o | output | 16 | Four 4-bit gain codes, channel 0 in the lowest nibble |
| mute_o | output | 4 | Per-channel mute flags |
| upd_o | output | 1 | One-cycle pulse when a gain code is written |
| upd_ch_o | output | 2 | Index of the channel written with upd_o |

## Verification
The bench first shifts a word and checks that no output moves. It then commits on each strobe polarity, which tells a correct edge choice apart from a swapped or level-sensitive one. It sends words to all four channels, with codes that include 0000 and 1111. This exposes any swap in channel decode, any slip in field position, and any error in the mute decode. It also sends words that differ only in the enable bit or the device bit. It sends an over-long burst, which separates keeping the last eight bits from counting the first eight. Finally, it re-strobes without shifting and holds each strobe static at both levels, to show that nothing commits except the specified edges.

// File: rtl/gwr_pkg.sv
package gwr_pkg;
   localparam int unsigned CODE_W = 4;
   localparam int unsigned CH_W   = 2;
   localparam int unsigned N_CH   = 1 << CH_W;
   localparam int unsigned WORD_W = CODE_W + CH_W + 2;

   typedef struct packed {
      logic              enable;
      logic              dev_sel;
      logic [CH_W-1:0]   chan;
      logic [CODE_W-1:0] code;
   } ctl_word_t;
endpackage

// File: rtl/gwr_sync.sv
module gwr_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gwr_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gwr_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg[k] <= RST_VAL;
            else         stg[k] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg[k] <= RST_VAL;
            else         stg[k] <= stg[k-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gwr_edge.sv
module gwr_edge #(
   parameter bit RISING  = 1'b1,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic edge_o
);
   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= RST_VAL;
      else         prev_q <= lvl_i;
   end

   if (RISING) begin : g_rise
      assign edge_o = lvl_i & ~prev_q;
   end else begin : g_fall
      assign edge_o = ~lvl_i & prev_q;
   end
endmodule

// File: rtl/gwr_shift.sv
module gwr_shift #(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              shift_en_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] word_o
);
   if (WORD_W < 2) begin : g_bad_word
      $error("gwr_shift: WORD_W must be at least 2");
   end

   logic [WORD_W-1:0] sr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         sr_q <= '0;
      else if (shift_en_i) sr_q <= {sr_q[WORD_W-2:0], bit_i};
   end

   assign word_o = sr_q;
endmodule

// File: rtl/gwr_bank.sv
module gwr_bank
   import gwr_pkg::*;
(
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   commit_i,
   input  ctl_word_t              word_i,
   input  logic                   dev_pin_i,
   output logic [N_CH*CODE_W-1:0] gain_o,
   output logic [N_CH-1:0]        mute_o,
   output logic                   upd_o,
   output logic [CH_W-1:0]        upd_ch_o
);
   logic accept;
   logic [CODE_W-1:0] gain_q [N_CH];

   assign accept = commit_i & word_i.enable & (word_i.dev_sel == dev_pin_i);

   for (genvar c = 0; c < N_CH; c++) begin : g_chan
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            gain_q[c] <= '0;
         else if (accept && (word_i.chan == CH_W'(c)))
            gain_q[c] <= word_i.code;
      end
      assign gain_o[c*CODE_W +: CODE_W] = gain_q[c];
      assign mute_o[c] = (gain_q[c] == '0);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         upd_o    <= 1'b0;
         upd_ch_o <= '0;
      end else begin
         upd_o <= accept;
         if (accept) upd_ch_o <= word_i.chan;
      end
   end
endmodule

// File: rtl/gain_word_rx.sv
module gain_word_rx
   import gwr_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   ser_clk_i,
   input  logic                   ser_dat_i,
   input  logic                   strb_hi_i,
   input  logic                   strb_lo_i,
   input  logic                   chip_sel_i,
   output logic [N_CH*CODE_W-1:0] gain_o,
   output logic [N_CH-1:0]        mute_o,
   output logic                   upd_o,
   output logic [CH_W-1:0]        upd_ch_o
);
   // Synchronized pin vector: [0] serial clock, [1] data, [2] high strobe, [3] low strobe.
   // Each strobe resets to its in-use idle level, so leaving reset never creates a commit edge.
   localparam logic [3:0] PIN_RST = 4'b1000;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gain_word_rx: SYNC_STAGES must be at least 2");
   end
   if (WORD_W != $bits(ctl_word_t)) begin : g_bad_fmt
      $error("gain_word_rx: word layout does not match WORD_W");
   end

   logic [3:0]        pins_s;
   logic              sclk_rise;
   logic              hi_fall;
   logic              lo_rise;
   logic              commit;
   logic [WORD_W-1:0] word_q;

   gwr_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({strb_lo_i, strb_hi_i, ser_dat_i, ser_clk_i}),
      .q_o    (pins_s)
   );

   gwr_edge #(.RISING(1'b1), .RST_VAL(PIN_RST[0])) u_sclk_edge (
      .clk_i (clk_i), .rst_ni (rst_ni), .lvl_i (pins_s[0]), .edge_o (sclk_rise)
   );

   gwr_edge #(.RISING(1'b0), .RST_VAL(PIN_RST[2])) u_hi_edge (
      .clk_i (clk_i), .rst_ni (rst_ni), .lvl_i (pins_s[2]), .edge_o (hi_fall)
   );

   gwr_edge #(.RISING(1'b1), .RST_VAL(PIN_RST[3])) u_lo_edge (
      .clk_i (clk_i), .rst_ni (rst_ni), .lvl_i (pins_s[3]), .edge_o (lo_rise)
   );

   assign commit = hi_fall | lo_rise;

   gwr_shift #(.WORD_W(WORD_W)) u_shift (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .shift_en_i (sclk_rise),
      .bit_i      (pins_s[1]),
      .word_o     (word_q)
   );

   gwr_bank u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .commit_i  (commit),
      .word_i    (ctl_word_t'(word_q)),
      .dev_pin_i (chip_sel_i),
      .gain_o    (gain_o),
      .mute_o    (mute_o),
      .upd_o     (upd_o),
      .upd_ch_o  (upd_ch_o)
   );
endmodule

// File: rtl/gain_word_rx_chk.sv
module gain_word_rx_chk
   import gwr_pkg::*;
(
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic                   cs_i,
   input logic                   commit,
   input logic [WORD_W-1:0]      word,
   input logic [N_CH*CODE_W-1:0] gain_o,
   input logic                   upd_o,
   input logic [CH_W-1:0]        upd_ch_o
);
   a_r6_change_needs_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(gain_o) |-> $past(commit));

   a_r3_enable_bit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o |-> $past(word[WORD_W-1]));

   a_r4_device_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o |-> ($past(word[WORD_W-2]) == $past(cs_i)));

   a_r5_channel_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o |-> (upd_ch_o == $past(word[CODE_W +: CH_W])));

   a_r5_code_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o |-> (gain_o[upd_ch_o*CODE_W +: CODE_W] == $past(word[CODE_W-1:0])));

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      a_r9_change_flags_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !$stable(gain_o[c*CODE_W +: CODE_W]) |-> (upd_o && (upd_ch_o == CH_W'(c))));
   end
endmodule

bind gain_word_rx gain_word_rx_chk u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .cs_i     (chip_sel_i),
   .commit   (commit),
   .word     (word_q),
   .gain_o   (gain_o),
   .upd_o    (upd_o),
   .upd_ch_o (upd_ch_o)
);

// File: tb/gain_word_rx_bench.sv
module gain_word_rx_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        sdat = 1'b0;
   logic        shi  = 1'b0;
   logic        slo  = 1'b1;
   logic        cs   = 1'b0;
   logic [15:0] gain;
   logic [3:0]  mute;
   logic        upd;
   logic [1:0]  upd_ch;

   int checks = 0;
   int fails  = 0;
   int upd_cnt = 0;
   int last_ch = -1;
   bit done = 1'b0;
   int exp_g [4];

   always #(CLK_P/2) clk = ~clk;

   gain_word_rx u_gain_word_rx (
      .clk_i (clk), .rst_ni (rst_n), .ser_clk_i (sclk), .ser_dat_i (sdat),
      .strb_hi_i (shi), .strb_lo_i (slo), .chip_sel_i (cs),
      .gain_o (gain), .mute_o (mute), .upd_o (upd), .upd_ch_o (upd_ch)
   );

   always @(posedge clk) begin
      if (upd) begin
         upd_cnt <= upd_cnt + 1;
         last_ch <= int'(upd_ch);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_all(input string tag);
      for (int c = 0; c < 4; c++) begin
         chk({tag, " gain"}, int'(gain[c*4 +: 4]), exp_g[c]);
         chk({tag, " R8 mute"}, int'(mute[c]), int'(exp_g[c] == 0));
      end
   endtask

   task automatic shift_bits(input logic [15:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk); sdat = v[i];
         idle(4); sclk = 1'b1;
         idle(4); sclk = 1'b0;
      end
      idle(2);
   endtask

   task automatic pulse_hi();
      @(negedge clk); shi = 1'b1; idle(5); shi = 1'b0; idle(6);
   endtask

   task automatic pulse_lo();
      @(negedge clk); slo = 1'b0; idle(5); slo = 1'b1; idle(6);
   endtask

   task automatic t_reset();
      idle(3);
      check_all("R1 reset");
      chk("R1 no update after reset", upd_cnt, 0);
   endtask

   task automatic t_basic();
      int c0 = upd_cnt;
      shift_bits(16'h88, 8);
      check_all("R6 shift only");
      chk("R6 no update while shifting", upd_cnt, c0);
      pulse_hi();
      exp_g[0] = 8;
      check_all("R7 high strobe commit");
      chk("R9 one pulse", upd_cnt, c0 + 1);
      chk("R9 channel index", last_ch, 0);
   endtask

   task automatic t_channels();
      logic [7:0] w [3] = '{8'h93, 8'hAF, 8'hB1};
      int v [3] = '{3, 15, 1};
      for (int k = 0; k < 3; k++) begin
         int c0 = upd_cnt;
         shift_bits(16'(w[k]), 8);
         pulse_lo();
         exp_g[k+1] = v[k];
         check_all("R5 channel decode");
         chk("R9 one pulse per word", upd_cnt, c0 + 1);
         chk("R5 R9 channel index", last_ch, k + 1);
      end
   endtask

   task automatic t_enable_off();
      int c0 = upd_cnt;
      shift_bits(16'h05, 8);
      pulse_hi();
      check_all("R3 disabled word");
      chk("R3 no pulse", upd_cnt, c0);
   endtask

   task automatic t_devsel();
      int c0 = upd_cnt;
      shift_bits(16'hC4, 8);
      pulse_hi();
      check_all("R4 device mismatch");
      chk("R4 no pulse", upd_cnt, c0);
      cs = 1'b1; idle(3);
      pulse_lo();
      exp_g[0] = 4;
      check_all("R10 R4 retained word recommit");
      chk("R10 pulse", upd_cnt, c0 + 1);
      pulse_hi();
      chk("R10 second recommit pulse", upd_cnt, c0 + 2);
      cs = 1'b0; idle(3);
   endtask

   task automatic t_mute();
      shift_bits(16'h90, 8);
      pulse_lo();
      exp_g[1] = 0;
      check_all("R8 code zero");
      chk("R8 mute ch1", int'(mute[1]), 1);
   endtask

   task automatic t_overlong();
      shift_bits(16'hFA6, 12);
      pulse_hi();
      exp_g[2] = 6;
      check_all("R2 last eight bits");
   endtask

   task automatic t_static_strobes();
      int c0 = upd_cnt;
      shift_bits(16'hB7, 8);
      @(negedge clk); shi = 1'b1; idle(10);
      check_all("R7 R11 high strobe rise held");
      chk("R11 no pulse high held", upd_cnt, c0);
      shift_bits(16'h8C, 8);
      @(negedge clk); slo = 1'b0; idle(10);
      check_all("R7 R11 low strobe fall held");
      chk("R11 no pulse low held", upd_cnt, c0);
      @(negedge clk); slo = 1'b1; idle(8);
      exp_g[0] = 12;
      check_all("R7 low strobe rise");
      chk("R9 pulse on low rise", upd_cnt, c0 + 1);
      @(negedge clk); shi = 1'b0; idle(8);
      check_all("R7 high strobe fall");
      chk("R9 pulse on high fall", upd_cnt, c0 + 2);
   endtask

   initial begin
      for (int c = 0; c < 4; c++) exp_g[c] = 0;
      idle(4);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_channels();
      t_enable_off();
      t_devsel();
      t_mute();
      t_overlong();
      t_static_strobes();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=hang expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule